// File: doc/BRIEF.md
# Prioritised Exception Cause Selector

This block takes the pending-exception flags of one instruction, laid out as a 16-bit vector indexed by cause number. It reports whether any flag is pending. It also gives the 4-bit cause code of the flag that wins under a fixed architectural ranking. The ranking is not numeric. Breakpoint comes first. Instruction-side faults follow, then environment calls from the most privileged level down, then misaligned accesses. Page faults come after that and access faults come last, with the store variant ahead of the load variant in each of those three groups.

A scope input selects which flags take part. In full scope, every defined cause is eligible. In fetch-only scope, only the four fetch-side causes (0, 1, 2, 12) survive and every other flag is cleared before selection. Positions 10 and 14 hold no defined cause and are always dropped. The result is captured into output registers in each cycle that a load strobe is high. The registers also hold a copy of the filtered vector, so downstream logic can see which flags survived.

Top module: `exc_cause_sel`

## Requirements
- R1: After reset, `res_valid` is 0, `res_cause` is 0 and `res_kept` is 0.
- R2: The outputs update only on a clock edge where `load` is 1. They take the value computed from `flags` and `fetch_only` at that edge. When `load` is 0 they hold their previous value.
- R3: Bits 10 and 14 of `flags` never appear in `res_kept` and never win the selection.
- R4: When `fetch_only` is 1, `res_kept` equals `flags & 16'h1007` (bits 0, 1, 2 and 12 only). When `fetch_only` is 0, `res_kept` equals `flags & 16'hBBFF`.
- R5: `res_valid` is 1 exactly when `res_kept` is non-zero.
- R6: When no flag survives, `res_cause` is 0.
- R7: When flags survive, `res_cause` is the surviving cause ranked highest in this order, from highest to lowest: 3, 12, 1, 2, 0, 11, 9, 8, 6, 4, 15, 13, 7, 5.
- R8: With exactly one surviving flag, `res_cause` equals that flag's bit position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Capture strobe for the result registers |
| fetch_only | input | 1 | 1: only fetch-side causes are eligible |
| flags | input | 16 | Pending-exception flags indexed by cause number |
| res_valid | output | 1 | Registered: some flag survived the filter |
| res_cause | output | 4 | Registered cause code of the winning flag |
| res_kept | output | 16 | Registered filtered flag vector |

## Verification
On every cycle, the checker confirms the following:
- The hold behaviour when the strobe is low.
- That undefined positions never reach the kept vector.
- That the valid bit tracks a non-empty kept vector.
- That a captured cause always points at a set bit of the kept vector.
- That fetch-only captures stay inside the fetch subset.

Only the bench's scenarios can show that the winner is the highest-ranked survivor. They do this by walking every single-flag case and many random multi-flag vectors in both scopes against an independent ranking walk.

// File: rtl/exc_sel_pkg.sv
package exc_sel_pkg;
   localparam int unsigned VEC_W   = 16;
   localparam int unsigned CODE_W  = $clog2(VEC_W);
   localparam int unsigned N_RANK  = 14;

   // fixed rank order, index 0 = highest priority
   function automatic logic [CODE_W-1:0] rank_code(input int unsigned r);
      case (r)
         0:  rank_code = 4'd3;
         1:  rank_code = 4'd12;
         2:  rank_code = 4'd1;
         3:  rank_code = 4'd2;
         4:  rank_code = 4'd0;
         5:  rank_code = 4'd11;
         6:  rank_code = 4'd9;
         7:  rank_code = 4'd8;
         8:  rank_code = 4'd6;
         9:  rank_code = 4'd4;
         10: rank_code = 4'd15;
         11: rank_code = 4'd13;
         12: rank_code = 4'd7;
         default: rank_code = 4'd5;
      endcase
   endfunction

   localparam logic [VEC_W-1:0] DEFINED_MASK = 16'hBBFF;
   localparam logic [VEC_W-1:0] FETCH_MASK   = 16'h1007;
endpackage

// File: rtl/exc_scope_filter.sv
module exc_scope_filter
   import exc_sel_pkg::*;
#(
   parameter logic [VEC_W-1:0] ALL_MASK = DEFINED_MASK,
   parameter logic [VEC_W-1:0] SUB_MASK = FETCH_MASK
) (
   input  logic             fetch_only,
   input  logic [VEC_W-1:0] raw,
   output logic [VEC_W-1:0] kept
);
   initial begin
      if ((SUB_MASK & ~ALL_MASK) != '0)
         $error("subset mask must lie inside defined mask");
   end

   always_comb begin
      kept = raw & (fetch_only ? SUB_MASK : ALL_MASK);
   end
endmodule

// File: rtl/exc_rank_pick.sv
module exc_rank_pick
   import exc_sel_pkg::*;
(
   input  logic [VEC_W-1:0]  kept,
   output logic              any,
   output logic [CODE_W-1:0] code
);
   logic [N_RANK-1:0] hit;
   logic [N_RANK-1:0] win;

   for (genvar r = 0; r < N_RANK; r++) begin : g_hit
      assign hit[r] = kept[rank_code(r)];
   end

   // one-hot grant: first hit in rank order
   assign win = hit & ~(hit - 1'b1);
   assign any = |hit;

   always_comb begin
      code = '0;
      for (int r = 0; r < N_RANK; r++)
         if (win[r]) code = code | rank_code(r);
   end
endmodule

// File: rtl/exc_cause_sel.sv
module exc_cause_sel
   import exc_sel_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              fetch_only,
   input  logic [15:0]       flags,
   output logic              res_valid,
   output logic [3:0]        res_cause,
   output logic [15:0]       res_kept
);
   logic [VEC_W-1:0]  kept_c;
   logic              any_c;
   logic [CODE_W-1:0] code_c;

   exc_scope_filter i_filter (
      .fetch_only (fetch_only),
      .raw        (flags),
      .kept       (kept_c)
   );

   exc_rank_pick i_pick (
      .kept (kept_c),
      .any  (any_c),
      .code (code_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_cause <= '0;
         res_kept  <= '0;
      end else if (load) begin
         res_valid <= any_c;
         res_cause <= code_c;
         res_kept  <= kept_c;
      end
   end
endmodule

// File: rtl/exc_cause_sel_chk.sv
module exc_cause_sel_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        load,
   input logic        fetch_only,
   input logic        res_valid,
   input logic [3:0]  res_cause,
   input logic [15:0] res_kept
);
   AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(res_kept) && $stable(res_cause) && $stable(res_valid)); // R2
   AST_NO_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
      (res_kept[10] == 1'b0) && (res_kept[14] == 1'b0)); // R3
   AST_FETCH_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
      load && fetch_only |=> (res_kept & ~16'h1007) == 16'h0); // R4
   AST_VALID_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid == (res_kept != 16'h0)); // R5
   AST_IDLE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> res_cause == 4'd0); // R6
   AST_CAUSE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> res_kept[res_cause]); // R7
   AST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(res_kept) == 1 |-> res_kept == (16'h1 << res_cause)); // R8
endmodule

bind exc_cause_sel exc_cause_sel_chk i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .load       (load),
   .fetch_only (fetch_only),
   .res_valid  (res_valid),
   .res_cause  (res_cause),
   .res_kept   (res_kept)
);

// File: tb/test_exc_cause_sel.sv
module test_exc_cause_sel;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic load = 1'b0;
   logic fetch_only = 1'b0;
   logic [15:0] flags = '0;
   logic res_valid;
   logic [3:0] res_cause;
   logic [15:0] res_kept;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   typedef struct packed { logic v; logic [3:0] c; logic [15:0] k; } exp_t;
   exp_t exp_q[$];

   always #2 clk = ~clk;

   exc_cause_sel i_exc_cause_sel (
      .clk(clk), .rst_n(rst_n), .load(load), .fetch_only(fetch_only),
      .flags(flags), .res_valid(res_valid), .res_cause(res_cause), .res_kept(res_kept)
   );

   function automatic exp_t model(input logic [15:0] f, input logic fo);
      int order[14] = '{3, 12, 1, 2, 0, 11, 9, 8, 6, 4, 15, 13, 7, 5};
      exp_t e;
      e.k = f & (fo ? 16'h1007 : 16'hBBFF);
      e.v = (e.k != 0);
      e.c = 0;
      for (int i = 13; i >= 0; i--)
         if (e.k[order[i]]) e.c = 4'(order[i]);
      return e;
   endfunction

   task automatic check(input string req, input exp_t e);
      n_chk++;
      if (res_valid !== e.v || res_cause !== e.c || res_kept !== e.k) begin
         n_err++;
         $display("FAIL %s: got v=%0b c=%0d k=%h exp v=%0b c=%0d k=%h",
                  req, res_valid, res_cause, res_kept, e.v, e.c, e.k);
      end
   endtask

   // driver: applies one load and queues the expectation
   task automatic drive(input logic [15:0] f, input logic fo);
      @(negedge clk);
      flags = f; fetch_only = fo; load = 1'b1;
      exp_q.push_back(model(f, fo));
      @(negedge clk);
      load = 1'b0;
   endtask

   // monitor: after each loaded edge, compare at the falling edge
   initial begin
      forever begin
         @(posedge clk);
         if (load && rst_n) begin
            @(negedge clk);
            if (exp_q.size() > 0) check("R7", exp_q.pop_front());
         end
      end
   end

   initial begin
      exp_t held;
      #1;
      check("R1", '0);
      #10 rst_n = 1'b1;
      // R8 every single flag, both scopes (R3 positions 10/14 masked)
      for (int b = 0; b < 16; b++) begin
         drive(16'h1 << b, 1'b0);
         drive(16'h1 << b, 1'b1);
      end
      // R6 empty, R3 undefined-only
      drive(16'h0, 1'b0);
      drive(16'h4400, 1'b0);
      // R4 fetch scope kills higher-ranked breakpoint
      drive(16'h1008, 1'b1);
      drive(16'hFFFF, 1'b0);
      drive(16'hFFFF, 1'b1);
      // R7 store before load pairs
      drive(16'hA0A0, 1'b0);
      drive(16'h2020, 1'b0);
      drive(16'h0030, 1'b0);
      for (int i = 0; i < 400; i++) drive(16'($urandom), 1'($urandom));
      // R2 hold with load low
      drive(16'h0808, 1'b0);
      held = model(16'h0808, 1'b0);
      @(negedge clk);
      flags = 16'hFFFF; fetch_only = 1'b1;
      @(negedge clk); @(negedge clk);
      check("R2", held);
      @(negedge clk);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_err++;
            $display("FAIL watchdog: got timeout exp completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
   end
endmodule